// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Store with Destination Filter

This block sits on the receive side of a small Ethernet host interface. Incoming frames arrive one byte per cycle with a valid strobe and an end-of-frame marker. Each frame is checked against its destination address. A frame passes if it is a group frame or if it carries this station's address. A frame that passes is stored at the start of the active one of two receive buffers. That buffer is then marked full and, when enabled, the next frame goes to the other buffer.

The host reaches the buffers and their control words over a simple 32-bit register bus with a one-cycle read latency. It drains a buffer and then releases it by clearing the buffer's full flag. When the first buffer's control word and the global enable both allow it, a one-cycle interrupt pulse marks every stored frame. If the active buffer is still full when a frame starts, the whole frame is thrown away. The active buffer stays as it was.

Top module: `eth_rxpp`

## Requirements
- R1: The bus window is 4*BUF_BYTES bytes, word addressed, with read data valid in the cycle after a read strobe. With the default BUF_BYTES of 2048 the layout is: receive buffer 0 starts at 0x1000 and its control word is at 0x17FC; receive buffer 1 starts at 0x1800 and its control word is at 0x1FFC; the interrupt enable word is at 0x07F8. Frame byte k is stored in word k/4 of the buffer, in bits 8*(k%4)+7 down to 8*(k%4).
- R2: A frame whose first byte has bit 7 set is accepted whatever its remaining address bytes are.
- R3: Any other frame is accepted only if its first six bytes equal the station address, where byte i is compared with sta_addr_i[8i+7:8i]. A frame that fails this check, or that ends before its sixth byte, leaves no trace in status or interrupt.
- R4: If the active buffer's full flag (control bit 0) is set when a frame begins, the frame is dropped whole. Buffer contents, flags and the active buffer all stay unchanged.
- R5: An accepted frame is stored from the first byte of the active buffer. That buffer's control bit 0 is set at the frame's last byte.
- R6: An accepted frame produces a one-cycle pulse on irq_o only when bit 3 of buffer 0's control word and bit 31 of the interrupt enable word are both set. Bit 3 of buffer 1's control word has no effect.
- R7: With PINGPONG=1 the active buffer toggles after each accepted frame. With PINGPONG=0 every frame goes to buffer 0.
- R8: After reset buffer 0 is active, both control words and the enable word read zero, and irq_o is low.
- R9: A frame longer than the space from the active buffer's base to the top of the window is rejected, with no flag, toggle or interrupt. That space is 2*BUF_BYTES bytes for buffer 0 and BUF_BYTES bytes for buffer 1. A frame of exactly that length is accepted.
- R10: A control word keeps bits 0 and 3 as written, and its other bits read zero. Writing it with bit 0 clear releases the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_data_i | input | 8 | Received frame byte |
| rx_valid_i | input | 1 | rx_data_i holds a byte this cycle |
| rx_last_i | input | 1 | This byte ends the frame |
| sta_addr_i | input | 48 | Station address, byte i in bits 8i+7:8i |
| bus_addr_i | input | log2(4*BUF_BYTES) | Byte address of the access (low two bits ignored) |
| bus_re_i | input | 1 | Read strobe |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_re_i |
| irq_o | output | 1 | One-cycle interrupt pulse per accepted frame |

## Verification
The hardest case to reach is a drop on a full buffer. With ping-pong on, both buffers have to be left full, so the stimulus stores two frames without releasing either. A third frame is then sent, and the bench shows that the flags, the stored first word and the chosen buffer are unchanged by releasing one buffer and seeing the next frame land there. The two length limits are reached by sending frames of exactly the limit and one byte more, and the active buffer is steered onto each base by the order of the table.

// File: rtl/eth_rxpp_pkg.sv
package eth_rxpp_pkg;
  localparam int unsigned STAT_BIT  = 0;
  localparam int unsigned IEN_BIT   = 3;
  localparam int unsigned GIE_BIT   = 31;
  localparam int unsigned ADDR_LEN  = 6;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_GIE,
    SEL_CTRL0,
    SEL_CTRL1,
    SEL_MEM
  } rd_sel_e;
endpackage

// File: rtl/eth_rxpp_filter.sv
module eth_rxpp_filter
  import eth_rxpp_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  localparam int unsigned MBW = $clog2(2 * BUF_BYTES),
  localparam int unsigned CW  = MBW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [7:0]     rx_data_i,
  input  logic           rx_valid_i,
  input  logic           rx_last_i,
  input  logic [47:0]    sta_addr_i,
  input  logic           act_i,
  input  logic           act_full_i,
  output logic           wr_en_o,
  output logic [MBW-1:0] wr_byte_o,
  output logic [7:0]     wr_data_o,
  output logic           commit_o
);

  logic          in_frame_q, match_q, grp_q, drop_q, ovf_q;
  logic [CW-1:0] cnt_q;

  logic          first;
  logic [CW-1:0] cnt, limit, base, wptr;
  logic          drop, over, match_n, grp_n;
  logic [2:0]    idx;
  logic [7:0]    sta_byte;

  always_comb begin
    first    = !in_frame_q;
    cnt      = first ? '0 : cnt_q;
    limit    = act_i ? CW'(BUF_BYTES) : CW'(2 * BUF_BYTES);
    base     = act_i ? CW'(BUF_BYTES) : '0;
    drop     = first ? act_full_i : drop_q;
    over     = (cnt >= limit) || (!first && ovf_q);
    idx      = (cnt < CW'(ADDR_LEN)) ? cnt[2:0] : 3'd0;
    sta_byte = sta_addr_i[{idx, 3'b000} +: 8];
    grp_n    = first ? rx_data_i[7] : grp_q;
    match_n  = (first ? 1'b1 : match_q) &&
               ((cnt >= CW'(ADDR_LEN)) || (rx_data_i == sta_byte));
    wptr     = base + cnt;
  end

  assign wr_en_o   = rx_valid_i && !drop && !over;
  assign wr_byte_o = wptr[MBW-1:0];
  assign wr_data_o = rx_data_i;
  // accept decided once the sixth address byte is in
  assign commit_o  = rx_valid_i && rx_last_i && !drop && !act_full_i && !over &&
                     (cnt >= CW'(ADDR_LEN - 1)) && (grp_n || match_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      match_q    <= 1'b0;
      grp_q      <= 1'b0;
      drop_q     <= 1'b0;
      ovf_q      <= 1'b0;
    end else if (rx_valid_i) begin
      in_frame_q <= !rx_last_i;
      cnt_q      <= (cnt == '1) ? cnt : cnt + 1'b1;
      match_q    <= match_n;
      grp_q      <= grp_n;
      drop_q     <= drop;
      ovf_q      <= over;
    end
  end

  p_commit_in_frame_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (in_frame_q && cnt_q >= CW'(ADDR_LEN - 1)));

  p_commit_fits_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (cnt_q < limit));

endmodule

// File: rtl/eth_rxpp_mem.sv
module eth_rxpp_mem #(
  parameter int unsigned BUF_BYTES = 2048,
  localparam int unsigned MBW   = $clog2(2 * BUF_BYTES),
  localparam int unsigned WORDS = (2 * BUF_BYTES) / 4,
  localparam int unsigned WAW   = MBW - 2
) (
  input  logic           clk_i,
  input  logic           wr_en_i,
  input  logic [MBW-1:0] wr_byte_i,
  input  logic [7:0]     wr_data_i,
  input  logic           rd_en_i,
  input  logic [WAW-1:0] rd_word_i,
  output logic [31:0]    rd_data_o
);

  logic [WAW-1:0] wr_word;
  logic [1:0]     wr_lane;

  assign wr_word = wr_byte_i[MBW-1:2];
  assign wr_lane = wr_byte_i[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_lane == 2'(g))) lane_mem[wr_word] <= wr_data_i;
      if (rd_en_i) rd_data_o[8*g +: 8] <= lane_mem[rd_word_i];
    end
  end

endmodule

// File: rtl/eth_rxpp_regs.sv
module eth_rxpp_regs
  import eth_rxpp_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter bit          PINGPONG  = 1'b1,
  localparam int unsigned AW  = $clog2(4 * BUF_BYTES),
  localparam int unsigned WAW = $clog2(2 * BUF_BYTES) - 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           bus_re_i,
  input  logic           bus_we_i,
  input  logic [31:0]    bus_wdata_i,
  output logic [31:0]    bus_rdata_o,
  input  logic           commit_i,
  input  logic [31:0]    mem_rdata_i,
  output logic           mem_rd_en_o,
  output logic [WAW-1:0] mem_rd_word_o,
  output logic           act_o,
  output logic           act_full_o,
  output logic           irq_o
);

  localparam logic [AW-1:0] GIE_A   = AW'(BUF_BYTES - 8);
  localparam logic [AW-1:0] RX_A    = AW'(2 * BUF_BYTES);
  localparam logic [AW-1:0] CTRL0_A = AW'(3 * BUF_BYTES - 4);
  localparam logic [AW-1:0] CTRL1_A = AW'(4 * BUF_BYTES - 4);

  logic [1:0] stat_q, ien_q;
  logic       gie_q, act_q, irq_q;
  rd_sel_e    sel_q, sel_d;
  logic [AW-1:0] a;
  logic       in_rx;
  logic       unused_bits;

  assign a           = {bus_addr_i[AW-1:2], 2'b00};
  assign in_rx       = (a >= RX_A);
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[30:4], bus_wdata_i[2:1]};

  assign mem_rd_en_o   = bus_re_i && in_rx;
  assign mem_rd_word_o = a[AW-2:2];

  always_comb begin
    if (a == GIE_A)        sel_d = SEL_GIE;
    else if (a == CTRL0_A) sel_d = SEL_CTRL0;
    else if (a == CTRL1_A) sel_d = SEL_CTRL1;
    else if (in_rx)        sel_d = SEL_MEM;
    else                   sel_d = SEL_ZERO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
      gie_q  <= 1'b0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      sel_q  <= SEL_ZERO;
    end else begin
      if (bus_we_i) begin
        if (a == CTRL0_A) begin
          stat_q[0] <= bus_wdata_i[STAT_BIT];
          ien_q[0]  <= bus_wdata_i[IEN_BIT];
        end
        if (a == CTRL1_A) begin
          stat_q[1] <= bus_wdata_i[STAT_BIT];
          ien_q[1]  <= bus_wdata_i[IEN_BIT];
        end
        if (a == GIE_A) gie_q <= bus_wdata_i[GIE_BIT];
      end
      // frame completion wins over a same-cycle host write
      if (commit_i) begin
        stat_q[act_q] <= 1'b1;
        if (PINGPONG) act_q <= ~act_q;
      end
      irq_q <= commit_i && ien_q[0] && gie_q;
      if (bus_re_i) sel_q <= sel_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (sel_q)
      SEL_GIE:   bus_rdata_o[GIE_BIT] = gie_q;
      SEL_CTRL0: begin
        bus_rdata_o[STAT_BIT] = stat_q[0];
        bus_rdata_o[IEN_BIT]  = ien_q[0];
      end
      SEL_CTRL1: begin
        bus_rdata_o[STAT_BIT] = stat_q[1];
        bus_rdata_o[IEN_BIT]  = ien_q[1];
      end
      SEL_MEM:   bus_rdata_o = mem_rdata_i;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign act_o      = act_q;
  assign act_full_o = stat_q[act_q];
  assign irq_o      = irq_q;

  p_commit_free_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !stat_q[act_q]);

  p_act_moves_on_commit_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(commit_i));

  p_irq_after_commit_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(commit_i));

  p_irq_single_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

endmodule

// File: rtl/eth_rxpp.sv
module eth_rxpp #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter bit          PINGPONG  = 1'b1,
  localparam int unsigned AW  = $clog2(4 * BUF_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_last_i,
  input  logic [47:0]   sta_addr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_re_i,
  input  logic          bus_we_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          irq_o
);

  localparam int unsigned MBW = $clog2(2 * BUF_BYTES);
  localparam int unsigned WAW = MBW - 2;

  logic           act, act_full, commit;
  logic           wr_en, mem_rd_en;
  logic [MBW-1:0] wr_byte;
  logic [7:0]     wr_data;
  logic [WAW-1:0] mem_rd_word;
  logic [31:0]    mem_rdata;

  eth_rxpp_filter #(.BUF_BYTES(BUF_BYTES)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_last_i  (rx_last_i),
    .sta_addr_i (sta_addr_i),
    .act_i      (act),
    .act_full_i (act_full),
    .wr_en_o    (wr_en),
    .wr_byte_o  (wr_byte),
    .wr_data_o  (wr_data),
    .commit_o   (commit)
  );

  eth_rxpp_mem #(.BUF_BYTES(BUF_BYTES)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_byte_i (wr_byte),
    .wr_data_i (wr_data),
    .rd_en_i   (mem_rd_en),
    .rd_word_i (mem_rd_word),
    .rd_data_o (mem_rdata)
  );

  eth_rxpp_regs #(.BUF_BYTES(BUF_BYTES), .PINGPONG(PINGPONG)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_addr_i    (bus_addr_i),
    .bus_re_i      (bus_re_i),
    .bus_we_i      (bus_we_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .commit_i      (commit),
    .mem_rdata_i   (mem_rdata),
    .mem_rd_en_o   (mem_rd_en),
    .mem_rd_word_o (mem_rd_word),
    .act_o         (act),
    .act_full_o    (act_full),
    .irq_o         (irq_o)
  );

endmodule

// File: tb/eth_rxpp_tb_top.sv
`timescale 1ns/1ps
module eth_rxpp_tb_top;
  localparam int unsigned BUF = 64;
  localparam int unsigned AW  = $clog2(4 * BUF);
  localparam logic [AW-1:0] GIE_A   = AW'(BUF - 8);
  localparam logic [AW-1:0] BUF0_A  = AW'(2 * BUF);
  localparam logic [AW-1:0] CTRL0_A = AW'(3 * BUF - 4);
  localparam logic [AW-1:0] BUF1_A  = AW'(3 * BUF);
  localparam logic [AW-1:0] CTRL1_A = AW'(4 * BUF - 4);
  localparam logic [47:0]   STA     = 48'h5A4B3C2D1E02;
  localparam int NV = 12;
  // {kind[13:12], len[11:0]}; kind 0 = own address, 1 = group, 2 = mismatch
  localparam logic [15:0] VEC [NV] = '{
    16'h000A, 16'h1008, 16'h200C, 16'h0004, 16'h1040, 16'h0041,
    16'h1040, 16'h0080, 16'h1081, 16'h0006, 16'h1005, 16'h0081};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0, np_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic re = 1'b0, we = 1'b0, tgt = 1'b0;
  logic [31:0] wdata = '0, rdata, np_rdata;
  logic irq, np_irq;
  int total = 0, bad = 0, irq_cnt = 0;
  bit model_act = 1'b0;
  bit [1:0] model_full = '0;

  always #4 clk = ~clk;

  eth_rxpp #(.BUF_BYTES(BUF), .PINGPONG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid && !np_en),
    .rx_last_i(rx_last), .sta_addr_i(STA), .bus_addr_i(addr), .bus_re_i(re && !tgt),
    .bus_we_i(we && !tgt), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  eth_rxpp #(.BUF_BYTES(BUF), .PINGPONG(1'b0)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid && np_en),
    .rx_last_i(rx_last), .sta_addr_i(STA), .bus_addr_i(addr), .bus_re_i(re && tgt),
    .bus_we_i(we && tgt), .bus_wdata_i(wdata), .bus_rdata_o(np_rdata), .irq_o(np_irq));

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic logic [7:0] fbyte(int kind, int k, int len);
    if (k < 6) begin
      case (kind)
        1:       return (k == 0) ? 8'h81 : 8'(8'h30 + k);
        2:       return (k == 5) ? ~STA[8*k +: 8] : STA[8*k +: 8];
        default: return STA[8*k +: 8];
      endcase
    end
    return 8'(k * 7 + len);
  endfunction

  function automatic logic [31:0] word0(int kind, int len);
    return {fbyte(kind, 3, len), fbyte(kind, 2, len), fbyte(kind, 1, len), fbyte(kind, 0, len)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(int kind, int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbyte(kind, k, len);
      rx_last  = (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(bit np, logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    tgt = np; addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = np ? np_rdata : rdata;
  endtask

  task automatic bus_write(bit np, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    tgt = np; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // sends a frame, predicts the outcome and checks flags, irq and first word
  task automatic run_frame(int kind, int len, bit irq_on);
    logic [31:0] c0, c1, w;
    int limit, irq0;
    bit acc;
    string tag;
    limit = model_act ? BUF : 2 * BUF;
    acc   = (kind != 2) && (len >= 6) && (len <= limit) && !model_full[model_act];
    if (model_full[model_act])      tag = "R4";
    else if (kind == 2 || len < 6)  tag = "R3";
    else if (len > limit)           tag = "R9";
    else if (kind == 1)             tag = "R2";
    else                            tag = "R5";
    irq0 = irq_cnt;
    send_frame(kind, len);
    if (acc) model_full[model_act] = 1'b1;
    bus_read(1'b0, CTRL0_A, c0);
    bus_read(1'b0, CTRL1_A, c1);
    check(c0[0] == model_full[0], tag, c0, 32'(model_full[0]));
    check(c1[0] == model_full[1], tag, c1, 32'(model_full[1]));
    check((irq_cnt - irq0) == ((acc && irq_on) ? 1 : 0), "R6",
          32'(irq_cnt - irq0), 32'((acc && irq_on) ? 1 : 0));
    if (acc) begin
      bus_read(1'b0, model_act ? BUF1_A : BUF0_A, w);
      check(w == word0(kind, len), "R1", w, word0(kind, len));
      model_act = ~model_act;
    end
  endtask

  task automatic release_all();
    bus_write(1'b0, CTRL0_A, 32'h8);
    bus_write(1'b0, CTRL1_A, 32'h0);
    model_full = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(irq == 1'b0, "R8", 32'(irq), 0);
    bus_read(1'b0, CTRL0_A, d); check(d == 0, "R8", d, 0);
    bus_read(1'b0, CTRL1_A, d); check(d == 0, "R8", d, 0);
    bus_read(1'b0, GIE_A, d);   check(d == 0, "R8", d, 0);

    // R10 control word field retention and release
    bus_write(1'b0, CTRL0_A, 32'hFFFF_FFFF);
    bus_read(1'b0, CTRL0_A, d); check(d == 32'h9, "R10", d, 32'h9);
    bus_write(1'b0, CTRL0_A, 32'h8);
    bus_read(1'b0, CTRL0_A, d); check(d == 32'h8, "R10", d, 32'h8);
    bus_write(1'b0, GIE_A, 32'h8000_0000);
    bus_read(1'b0, GIE_A, d); check(d == 32'h8000_0000, "R1", d, 32'h8000_0000);

    // table walk; R7 toggling is implied by the predicted buffer of each frame
    for (int v = 0; v < NV; v++) begin
      run_frame(int'(VEC[v][13:12]), int'(VEC[v][11:0]), 1'b1);
      release_all();
    end

    // R4 drop on full active buffer
    run_frame(0, 8, 1'b1);
    run_frame(1, 9, 1'b1);
    bus_read(1'b0, model_act ? BUF1_A : BUF0_A, keep);
    run_frame(1, 12, 1'b1);
    bus_read(1'b0, model_act ? BUF1_A : BUF0_A, d);
    check(d == keep, "R4", d, keep);
    if (model_act) begin
      bus_write(1'b0, CTRL1_A, 32'h0); model_full[1] = 1'b0;
    end else begin
      bus_write(1'b0, CTRL0_A, 32'h8); model_full[0] = 1'b0;
    end
    run_frame(0, 7, 1'b1);
    release_all();

    // R6 interrupt gating
    bus_write(1'b0, GIE_A, 32'h0);
    run_frame(1, 10, 1'b0);
    release_all();
    bus_write(1'b0, GIE_A, 32'h8000_0000);
    bus_write(1'b0, CTRL0_A, 32'h0);
    bus_write(1'b0, CTRL1_A, 32'h8);
    model_full = '0;
    run_frame(0, 10, 1'b0);
    run_frame(0, 11, 1'b0);
    release_all();

    // R7 ping-pong disabled: every frame lands in buffer 0
    np_en = 1'b1;
    send_frame(0, 8);
    bus_read(1'b1, CTRL0_A, d); check(d[0] == 1'b1, "R7", d, 1);
    bus_read(1'b1, CTRL1_A, d); check(d[0] == 1'b0, "R7", d, 0);
    bus_write(1'b1, CTRL0_A, 32'h0);
    send_frame(1, 9);
    bus_read(1'b1, CTRL0_A, d); check(d[0] == 1'b1, "R7", d, 1);
    bus_read(1'b1, CTRL1_A, d); check(d[0] == 1'b0, "R7", d, 0);
    bus_read(1'b1, BUF0_A, d); check(d == word0(1, 9), "R7", d, word0(1, 9));
    np_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule